// File: doc/BRIEF.md
# Slow RC Oscillator Calibration Sequencer

This block is a hardware sequencer that trims a low-frequency RC oscillator so that a fractional clock divider downstream of it produces a 1024 Hz tick. It drives two control words. The first is a small signed coarse-tune value for the oscillator's analog trim. The second is a 16-bit divider word in unsigned 5.11 fixed point: bits 15:11 hold the integer part and bits 10:0 hold the fraction. It reads a period measurement, which is the count of reference-clock cycles in a fixed number of oscillator cycles. The oscillator and the period counter are outside the block.

A pulse on `start_i` launches the sequence. The block first loads both control words with their reset values. It then waits for the measurement to settle and reads the period once. From that reading it derives a rounded, clamped coarse step and applies it. Next it takes eight period readings, each after its own settle wait, and averages them with rounding. Finally it divides a fixed numerator by the average in a bit-serial restoring divider and writes the quotient as the divider word. `done_o` then rises and stays high until the next accepted start.

Top module: `slowrc_cal_seq`

## Requirements
- R1: An accepted start loads `tune_o` with 0 and `divword_o` with 0x5000 (divide by 10.0) on the start edge, clears `done_o` and raises `busy_o`.
- R2: Every settle wait lasts `WAIT_CYCLES` clock cycles. The coarse tune is written on clock edge `WAIT_CYCLES`+1 after the start edge, so `tune_o` still holds its reset value after edge `WAIT_CYCLES`.
- R3: The coarse step is (19600 − P) / 800, with the quotient truncated toward zero. P is the period input sampled on the tune edge.
- R4: The step is clamped to the range −8 to +7 and presented on `tune_o` as a 4-bit two's-complement value.
- R5: Eight period samples are taken, on edges 2·`WAIT_CYCLES`+2+k·(`WAIT_CYCLES`+1) after the start edge for k = 0..7. Their average is (sum + 4) / 8, using integer division.
- R6: `divword_o` becomes the low 16 bits of 384000000 divided by that average. It changes only on an accepted start or on that final write.
- R7: `done_o` rises one cycle after the divider word is written, and `busy_o` falls at the same time. `done_o` then stays high until the next accepted start.
- R8: A start request that arrives while `busy_o` is high is ignored. The run in progress continues unchanged.
- R9: After reset, `tune_o` is 0, `divword_o` is 0x5000, and `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| period_i | input | PERIOD_W (16) | Measured oscillator period in reference cycles |
| tune_o | output | TUNE_W (4) | Signed coarse-tune value to the oscillator |
| divword_o | output | DIV_W (16) | 5.11 fixed-point word for the fractional divider |
| busy_o | output | 1 | High while a calibration run is in progress |
| done_o | output | 1 | High after a run has written its divider word |

## Verification
The assertions assume that the period input is nonzero whenever it is sampled and that the design is only started from reset or from an idle state. Under those conditions the step and sample strobes always follow an expired settle timer. The bench drives `period_i` from a schedule built from the stated sample edges. It applies one value for the tune read and a different value in each sample window, so a read taken in the wrong window gives a wrong result. Sample bases stay nonzero, and some runs use small averages to exercise truncation of quotients wider than 16 bits. Extra start pulses are placed in the middle of the sample phase.

// File: rtl/slowrc_cal_pkg.sv
package slowrc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE_TUNE,
    ST_TUNE,
    ST_SETTLE_SAMP,
    ST_SAMPLE,
    ST_DIV_GO,
    ST_DIV_RUN,
    ST_FINISH
  } seq_state_e;

  // Rounded coarse step: offset by half a step, truncate toward zero, clamp.
  function automatic int coarse_steps(input int period, input int target,
                                      input int step, input int lo, input int hi);
    int diff;
    int q;
    diff = target + (step / 2) - period;
    q    = diff / step;
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q;
  endfunction

  // Mean of 2**lg samples with round-half-up.
  function automatic longint unsigned round_avg(input longint unsigned sum, input int lg);
    longint unsigned half;
    half = (64'd1 << lg) >> 1;
    return (sum + half) >> lg;
  endfunction

endpackage

// File: rtl/slowrc_settle_timer.sv
module slowrc_settle_timer #(
  parameter int CYCLES = 51000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic expire_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slowrc_period_avg.sv
module slowrc_period_avg
  import slowrc_cal_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int LOG2N    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [PERIOD_W-1:0] sample_i,
  output logic [PERIOD_W-1:0] avg_o
);
  localparam int SUM_W = PERIOD_W + LOG2N;

  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_q + SUM_W'(sample_i);
  end

  assign avg_o = PERIOD_W'(round_avg(64'(sum_q), LOG2N));
endmodule

// File: rtl/slowrc_restoring_div.sv
module slowrc_restoring_div #(
  parameter int NUM_W = 29,
  parameter int DEN_W = 16,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dividend_i,
  input  logic [DEN_W-1:0] divisor_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quot_o
);
  localparam int IT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] shreg_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] dsr_q;
  logic [IT_W-1:0]  iter_q;
  logic             run_q;
  logic             done_q;

  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] trial;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q, shreg_q[NUM_W-1]};
    trial  = {1'b0, rem_sh} - {2'b00, dsr_q};
    fits   = !trial[DEN_W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rem_q   <= '0;
      dsr_q   <= '0;
      iter_q  <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        shreg_q <= dividend_i;
        rem_q   <= '0;
        dsr_q   <= divisor_i;
        iter_q  <= IT_W'(NUM_W);
        run_q   <= 1'b1;
      end else if (run_q) begin
        shreg_q <= {shreg_q[NUM_W-2:0], fits};
        rem_q   <= fits ? trial[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        iter_q  <= iter_q - 1'b1;
        if (iter_q == IT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = shreg_q[Q_W-1:0];
endmodule

// File: rtl/slowrc_cal_seq.sv
module slowrc_cal_seq
  import slowrc_cal_pkg::*;
#(
  parameter int PERIOD_W      = 16,
  parameter int TUNE_W        = 4,
  parameter int DIV_W         = 16,
  parameter int SAMPLES_LOG2  = 3,
  parameter int WAIT_CYCLES   = 51000,
  parameter int TARGET_PERIOD = 19200,
  parameter int STEP_PERIOD   = 800,
  parameter int NUMERATOR     = 384000000,
  parameter int NUM_W         = 29,
  parameter logic [DIV_W-1:0]  DIV_RESET  = 16'h5000,
  parameter logic [TUNE_W-1:0] TUNE_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [TUNE_W-1:0]   tune_o,
  output logic [DIV_W-1:0]    divword_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int NSAMP   = 1 << SAMPLES_LOG2;
  localparam int CNT_W   = SAMPLES_LOG2 + 1;
  localparam int TUNE_HI = (1 << (TUNE_W - 1)) - 1;
  localparam int TUNE_LO = -(1 << (TUNE_W - 1));

  seq_state_e        state_q;
  logic [CNT_W-1:0]  samp_cnt_q;
  logic [TUNE_W-1:0] tune_q;
  logic [DIV_W-1:0]  divword_q;
  logic              done_q;

  // Named internal events, also observed by the checker.
  logic load_evt, wait_expire, tune_wr, samp_take, last_samp;
  logic div_go, div_done, div_wr, timer_arm;
  logic [PERIOD_W-1:0] avg_w;
  logic [DIV_W-1:0]    quot_w;
  logic [TUNE_W-1:0]   tune_next;

  assign load_evt  = (state_q == ST_IDLE) && start_i;
  assign tune_wr   = (state_q == ST_TUNE);
  assign samp_take = (state_q == ST_SAMPLE);
  assign last_samp = samp_take && (samp_cnt_q == CNT_W'(NSAMP - 1));
  assign div_go    = (state_q == ST_DIV_GO);
  assign div_wr    = (state_q == ST_DIV_RUN) && div_done;
  assign timer_arm = load_evt || tune_wr || (samp_take && !last_samp);

  assign tune_next = TUNE_W'(coarse_steps(int'(period_i), TARGET_PERIOD,
                                          STEP_PERIOD, TUNE_LO, TUNE_HI));

  slowrc_settle_timer #(
    .CYCLES (WAIT_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (timer_arm),
    .expire_o (wait_expire)
  );

  slowrc_period_avg #(
    .PERIOD_W (PERIOD_W),
    .LOG2N    (SAMPLES_LOG2)
  ) u_avg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tune_wr),
    .add_i    (samp_take),
    .sample_i (period_i),
    .avg_o    (avg_w)
  );

  slowrc_restoring_div #(
    .NUM_W (NUM_W),
    .DEN_W (PERIOD_W),
    .Q_W   (DIV_W)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_go),
    .dividend_i (NUM_W'(NUMERATOR)),
    .divisor_i  (avg_w),
    .done_o     (div_done),
    .quot_o     (quot_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      samp_cnt_q <= '0;
      tune_q     <= TUNE_RESET;
      divword_q  <= DIV_RESET;
      done_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            tune_q    <= TUNE_RESET;
            divword_q <= DIV_RESET;
            done_q    <= 1'b0;
            state_q   <= ST_SETTLE_TUNE;
          end
        end
        ST_SETTLE_TUNE: if (wait_expire) state_q <= ST_TUNE;
        ST_TUNE: begin
          tune_q     <= tune_next;
          samp_cnt_q <= '0;
          state_q    <= ST_SETTLE_SAMP;
        end
        ST_SETTLE_SAMP: if (wait_expire) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          samp_cnt_q <= samp_cnt_q + 1'b1;
          state_q    <= last_samp ? ST_DIV_GO : ST_SETTLE_SAMP;
        end
        ST_DIV_GO: state_q <= ST_DIV_RUN;
        ST_DIV_RUN: begin
          if (div_done) begin
            divword_q <= quot_w;
            state_q   <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tune_o    = tune_q;
  assign divword_o = divword_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/slowrc_cal_chk.sv
module slowrc_cal_chk #(
  parameter int TUNE_W = 4,
  parameter int DIV_W  = 16,
  parameter int NSAMP  = 8,
  parameter logic [DIV_W-1:0]  DIV_RESET  = 16'h5000,
  parameter logic [TUNE_W-1:0] TUNE_RESET = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [TUNE_W-1:0] tune_o,
  input logic [DIV_W-1:0]  divword_o,
  input logic              load_evt,
  input logic              wait_expire,
  input logic              tune_wr,
  input logic              samp_take,
  input logic              div_go,
  input logic              div_wr
);
  localparam int SC_W = $clog2(NSAMP + 1) + 1;

  logic [SC_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= '0;
    else if (load_evt)  seen_q <= '0;
    else if (samp_take) seen_q <= seen_q + 1'b1;
  end

  AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (tune_o == TUNE_RESET && divword_o == DIV_RESET && busy_o && !done_o)); // R1

  AST_TUNE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    tune_wr |-> $past(wait_expire)); // R2

  AST_SAMPLE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    samp_take |-> $past(wait_expire)); // R5

  AST_SAMPLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> (seen_q == SC_W'(NSAMP))); // R5

  AST_DIVWORD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divword_o) |-> $past(div_wr || load_evt)); // R6

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(div_wr, 2)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !div_wr) |=> $stable(divword_o)); // R8
endmodule

bind slowrc_cal_seq slowrc_cal_chk #(
  .TUNE_W     (TUNE_W),
  .DIV_W      (DIV_W),
  .NSAMP      (NSAMP),
  .DIV_RESET  (DIV_RESET),
  .TUNE_RESET (TUNE_RESET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tune_o      (tune_o),
  .divword_o   (divword_o),
  .load_evt    (load_evt),
  .wait_expire (wait_expire),
  .tune_wr     (tune_wr),
  .samp_take   (samp_take),
  .div_go      (div_go),
  .div_wr      (div_wr)
);

// File: tb/slowrc_cal_seq_tb.sv
module slowrc_cal_seq_tb;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] period_i = 16'd19200;
  logic [3:0]  tune_o;
  logic [15:0] divword_o;
  logic        busy_o;
  logic        done_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  slowrc_cal_seq #(
    .WAIT_CYCLES (W)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .period_i  (period_i),
    .tune_o    (tune_o),
    .divword_o (divword_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_tune(input int p);
    int d;
    int q;
    d = 19600 - p;
    if (d >= 0) q = d / 800;
    else        q = -((-d) / 800);
    if (q > 7)  q = 7;
    if (q < -8) q = -8;
    return q;
  endfunction

  task automatic run_case(input int p_tune, input int base, input int seed, input bit inject);
    int samp[8];
    longint sum;
    longint avg;
    longint exp_div;
    int exp_t;
    bit got_done;
    sum = 0;
    for (int k = 0; k < 8; k++) begin
      samp[k] = base + ((seed + k * 3) % 11);
      sum += samp[k];
    end
    avg     = (sum + 4) / 8;
    exp_div = (64'd384000000 / avg) & 64'hFFFF;
    exp_t   = exp_tune(p_tune);

    @(negedge clk);
    start_i  = 1'b1;
    period_i = 16'(p_tune);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 tune load", longint'(tune_o), 0);
    chk("R1 divword load", longint'(divword_o), 64'h5000);
    chk("R1 done clear", longint'(done_o), 0);

    got_done = 1'b0;
    for (int n = 1; n <= 400 && !got_done; n++) begin
      if (n <= W + 1) period_i = 16'(p_tune);
      else begin
        int k;
        k = (n - W - 2) / (W + 1);
        if (k > 7) k = 7;
        period_i = 16'(samp[k]);
      end
      start_i = inject && (n == 3 * W);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (n == W)     chk("R2 tune before settle end", longint'($signed(tune_o)), 0);
      if (n == W + 1) chk("R3 R4 coarse tune", longint'($signed(tune_o)), exp_t);
      if (inject && n == 3 * W) chk("R8 busy kept", longint'(busy_o), 1);
      if (done_o) begin
        got_done = 1'b1;
        chk("R5 R6 divword at done", longint'(divword_o), exp_div);
        chk("R7 busy low at done", longint'(busy_o), 0);
      end
    end
    chk("R7 done reached", longint'(got_done), 1);
    repeat (3) @(negedge clk);
    chk("R7 done held", longint'(done_o), 1);
    chk("R4 tune held", longint'($signed(tune_o)), exp_t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset tune", longint'(tune_o), 0);
    chk("R9 reset divword", longint'(divword_o), 64'h5000);
    chk("R9 reset done", longint'(done_o), 0);
    chk("R9 reset busy", longint'(busy_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Step boundaries: truncation toward zero and clamp edges (R3, R4).
    run_case(19200, 19200, 0, 1'b0);
    run_case(19999, 19200, 1, 1'b0);
    run_case(20399, 19200, 2, 1'b1);
    run_case(20400, 19200, 3, 1'b0);
    run_case(18800, 19200, 4, 1'b0);
    run_case(13201, 19200, 5, 1'b0);
    run_case(13200, 19200, 6, 1'b0);
    run_case(12000, 19200, 7, 1'b1);
    run_case(25999, 19200, 8, 1'b0);
    run_case(26000, 19200, 9, 1'b0);
    run_case(30000, 19200, 10, 1'b0);

    // Sweep of tune periods, sample bases and late start pulses.
    for (int i = 0; i < 48; i++) begin
      run_case(9000 + i * 557,
               (i % 6 == 5) ? 3000 + i * 11 : 16000 + i * 83,
               i * 7, (i % 4) == 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R7 watchdog done_o actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule